// File: doc/BRIEF.md
# Outbound Address Window Translator

This block maps local bus addresses that fall inside a fixed 256 MB outbound window (0x6000_0000 to 0x6FFF_FFFF) onto 64-bit link addresses. The window is cut into 32 regions of equal size, and the size is programmable as 1, 2, 4 or 8 MB. Each region holds its own upper-address offset and its own enable. A translated address keeps the local address bits below the region boundary. The region's offset supplies every bit above that boundary, up to bit 63.

A requester presents a 32-bit address with a valid strobe. One clock later the block returns the translated address together with a hit flag or a miss flag. A simple write port programs four things: the global enable, the region size, each region's low offset word and each region's high offset word. When the global enable is clear, addresses pass through unchanged, extended with zeros to 64 bits.

Top module: `ob_xlate_top`

## Requirements
- R1: After reset, rsp_valid, rsp_hit and rsp_miss are low and rsp_addr is zero. The global enable and all region enables are clear, all offsets are zero and the size code is 0.
- R2: rsp_valid is high in the cycle after each cycle in which req_valid is high, and low otherwise.
- R3: While the global enable is clear, a request returns rsp_hit=1, rsp_miss=0 and rsp_addr = {32'h0, req_addr}, for any address.
- R4: While the global enable is set, an address whose bits [31:28] are not 4'h6 returns rsp_miss=1, rsp_hit=0 and rsp_addr = 0.
- R5: The region index is req_addr[24+s:20+s], where s is the size code (0=1 MB, 1=2 MB, 2=4 MB, 3=8 MB). Window address bits above the index field do not affect the choice of region.
- R6: A request to an enabled region returns rsp_hit=1 and rsp_addr = {hi_offset, lo_offset[31:20+s], req_addr[19+s:0]}.
- R7: A request inside the window to a region whose lo_offset bit 0 is 0 returns rsp_miss=1, rsp_hit=0 and rsp_addr = 0.
- R8: lo_offset bits [19+s:20] have no effect on the translated address.
- R9: The configuration port uses cfg_sel. Code 0 writes the control word, whose bit 0 is the global enable. Code 1 writes the size code from cfg_wdata[1:0]. Code 2 writes lo_offset of region cfg_idx, and code 3 writes hi_offset of region cfg_idx. A write applies from the next cycle, so a request in the same cycle as the write uses the old values.
- R10: While rsp_valid is high, exactly one of rsp_hit and rsp_miss is high. While rsp_valid is low, both are low.
- R11: hi_offset of the selected region drives rsp_addr[63:32] on a hit while the global enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Local address |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select (see R9) |
| cfg_idx | input | 5 | Region number for offset writes |
| cfg_wdata | input | 32 | Configuration write data |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_addr | output | 64 | Translated link address |
| rsp_hit | output | 1 | Translation succeeded |
| rsp_miss | output | 1 | Outside window or region disabled |

## Verification
The hardest case is a configuration write and a request that land on the same clock edge. The request must be translated with the old settings, and the new settings must apply to the request on the next edge. The bench drives a size-code change and a request in the same cycle, then repeats the same address, so that the two cycles fall in different regions. The bench also changes the size code to 8 MB with a non-zero offset bit below the boundary. This shows that the index field moves with the size and that the hidden offset bits drop out of the result.

// File: rtl/ob_xlate_pkg.sv
package ob_xlate_pkg;
  localparam int ADDR_W     = 32;
  localparam int HI_W       = 32;
  localparam int LINK_W     = ADDR_W + HI_W;
  localparam int NUM_REG    = 32;
  localparam int IDX_W      = $clog2(NUM_REG);
  localparam int BASE_SHIFT = 20;
  localparam int SIZE_W     = 2;
  localparam int TAG_LSB    = BASE_SHIFT + IDX_W + (1 << SIZE_W) - 1;
  localparam int TAG_W      = ADDR_W - TAG_LSB;
  localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(6);
  localparam int BASE_W     = ADDR_W - BASE_SHIFT;

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'd0,
    SEL_SIZE   = 2'd1,
    SEL_OFS_LO = 2'd2,
    SEL_OFS_HI = 2'd3
  } cfg_sel_e;

  typedef struct packed {
    logic [HI_W-1:0]   hi;
    logic [BASE_W-1:0] base;
    logic              en;
  } region_t;
endpackage

// File: rtl/ob_cfg_regs.sv
module ob_cfg_regs
  import ob_xlate_pkg::*;
#(
  parameter int N = NUM_REG,
  parameter int IW = IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [IW-1:0]     idx,
  input  logic [31:0]       wdata,
  output logic              glob_en,
  output logic [SIZE_W-1:0] size_code,
  output region_t           tbl [N]
);
  logic              glob_en_nxt;
  logic [SIZE_W-1:0] size_nxt;
  logic              unused_wdata;

  assign unused_wdata = ^wdata[BASE_SHIFT-1:SIZE_W];

  always_comb begin
    glob_en_nxt = glob_en;
    size_nxt    = size_code;
    if (we && sel == SEL_CTRL) glob_en_nxt = wdata[0];
    if (we && sel == SEL_SIZE) size_nxt    = wdata[SIZE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      glob_en   <= 1'b0;
      size_code <= '0;
    end else if (we) begin
      glob_en   <= glob_en_nxt;
      size_code <= size_nxt;
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_region
    region_t nxt;
    logic    hit_w;
    assign hit_w = we && (idx == IW'(g));
    always_comb begin
      nxt = tbl[g];
      if (hit_w && sel == SEL_OFS_LO) begin
        nxt.base = wdata[31:BASE_SHIFT];
        nxt.en   = wdata[0];
      end
      if (hit_w && sel == SEL_OFS_HI) nxt.hi = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     tbl[g] <= '0;
      else if (hit_w) tbl[g] <= nxt;
    end
  end
endmodule

// File: rtl/ob_region_decode.sv
module ob_region_decode
  import ob_xlate_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size_code,
  output logic              in_win,
  output logic [IDX_W-1:0]  idx
);
  assign in_win = (addr[ADDR_W-1:TAG_LSB] == WIN_TAG);
  assign idx    = addr[BASE_SHIFT + int'(size_code) +: IDX_W];
endmodule

// File: rtl/ob_addr_compose.sv
module ob_addr_compose
  import ob_xlate_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic [SIZE_W-1:0] size_code,
  input  region_t           ent,
  output logic [LINK_W-1:0] link
);
  logic [ADDR_W-1:0] keep_mask;
  logic [ADDR_W-1:0] low_word;

  assign keep_mask = (ADDR_W'(1) << (BASE_SHIFT + int'(size_code))) - ADDR_W'(1);
  assign low_word  = ({ent.base, {BASE_SHIFT{1'b0}}} & ~keep_mask) | (addr & keep_mask);
  assign link      = {ent.hi, low_word};
endmodule

// File: rtl/ob_xlate_top.sv
module ob_xlate_top
  import ob_xlate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       req_addr,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [4:0]        cfg_idx,
  input  logic [31:0]       cfg_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_addr,
  output logic              rsp_hit,
  output logic              rsp_miss
);
  logic              glob_en;
  logic [SIZE_W-1:0] size_code;
  region_t           tbl [NUM_REG];
  logic              in_win;
  logic [IDX_W-1:0]  idx;
  region_t           ent;
  logic [LINK_W-1:0] link;
  logic [LINK_W-1:0] addr_nxt;
  logic              hit_nxt, miss_nxt;

  ob_cfg_regs #(.N(NUM_REG), .IW(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .idx(cfg_idx),
    .wdata(cfg_wdata), .glob_en(glob_en), .size_code(size_code), .tbl(tbl)
  );

  ob_region_decode u_dec (
    .addr(req_addr), .size_code(size_code), .in_win(in_win), .idx(idx)
  );

  assign ent = tbl[idx];

  ob_addr_compose u_cmp (
    .addr(req_addr), .size_code(size_code), .ent(ent), .link(link)
  );

  always_comb begin
    addr_nxt = '0;
    hit_nxt  = 1'b0;
    miss_nxt = 1'b0;
    if (!glob_en) begin
      addr_nxt = {{HI_W{1'b0}}, req_addr};
      hit_nxt  = 1'b1;
    end else if (in_win && ent.en) begin
      addr_nxt = link;
      hit_nxt  = 1'b1;
    end else begin
      miss_nxt = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_hit   <= req_valid & hit_nxt;
      rsp_miss  <= req_valid & miss_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rsp_addr <= '0;
    else if (req_valid) rsp_addr <= addr_nxt;
  end
endmodule

// File: rtl/ob_xlate_chk.sv
module ob_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        glob_en,
  input logic        rsp_valid,
  input logic [63:0] rsp_addr,
  input logic        rsp_hit,
  input logic        rsp_miss
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R2
  AST_IDLE_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit && !rsp_miss); // R10
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones({rsp_hit, rsp_miss}) == 1); // R10
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !glob_en |=> rsp_hit && rsp_addr == {32'h0, $past(req_addr)}); // R3
  AST_OUT_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && glob_en && req_addr[31:28] != 4'h6 |=> rsp_miss); // R4
  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_miss |-> rsp_addr == 64'h0); // R7
  AST_LOW_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_hit |-> rsp_addr[19:0] == $past(req_addr[19:0])); // R6
endmodule

bind ob_xlate_top ob_xlate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
  .glob_en(glob_en), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
  .rsp_hit(rsp_hit), .rsp_miss(rsp_miss)
);

// File: tb/ob_xlate_top_test.sv
module ob_xlate_top_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic        rsp_valid, rsp_hit, rsp_miss;
  logic [63:0] rsp_addr;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  ob_xlate_top uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_hit(rsp_hit), .rsp_miss(rsp_miss)
  );

  // {address, expected link address, expected hit}, 1 MB regions, enable set
  localparam int NV = 8;
  localparam logic [96:0] VEC [NV] = '{
    {32'h6001_5678, 64'h0000_0000_9001_5678, 1'b1},
    {32'h6012_3456, 64'h0000_0012_A032_3456, 1'b1},
    {32'h61F0_0010, 64'h0000_0000_1230_0010, 1'b1},
    {32'h6FFF_FFFF, 64'h0000_0000_123F_FFFF, 1'b1},
    {32'h6000_0000, 64'h0000_0000_9000_0000, 1'b1},
    {32'h6020_0000, 64'h0, 1'b0},
    {32'h7000_0000, 64'h0, 1'b0},
    {32'h5FFF_FFFF, 64'h0, 1'b0}
  };

  task automatic check(input string req, input logic [63:0] a, input logic h,
                       input logic m, input logic v,
                       input logic [63:0] ea, input logic eh, input logic em,
                       input logic ev);
    checks++;
    if (a !== ea || h !== eh || m !== em || v !== ev) begin
      errors++;
      $display("FAIL %s: got addr=%h hit=%b miss=%b valid=%b, expected addr=%h hit=%b miss=%b valid=%b",
               req, a, h, m, v, ea, eh, em, ev);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [4:0] i, input logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_idx = i; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic xlate(input string req, input logic [31:0] a,
                       input logic [63:0] ea, input logic eh);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check(req, rsp_addr, rsp_hit, rsp_miss, rsp_valid, ea, eh, !eh, 1'b1);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", rsp_addr, rsp_hit, rsp_miss, rsp_valid, 64'h0, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", rsp_addr, rsp_hit, rsp_miss, rsp_valid, 64'h0, 1'b0, 1'b0, 1'b0);
    // R3 pass-through while disabled, inside and outside the window
    xlate("R3", 32'h6001_5678, 64'h0000_0000_6001_5678, 1'b1);
    xlate("R3", 32'h1234_5678, 64'h0000_0000_1234_5678, 1'b1);
    // R2 / R10 idle cycle: no valid, no flags
    @(negedge clk);
    check("R2", rsp_addr, rsp_hit, rsp_miss, rsp_valid, 64'h0000_0000_1234_5678, 1'b0, 1'b0, 1'b0);

    // program, using the R9 encoding
    wr(2'd2, 5'd0,  32'h9000_0001);
    wr(2'd3, 5'd0,  32'h0);
    wr(2'd2, 5'd1,  32'hA030_0001);
    wr(2'd3, 5'd1,  32'h0000_0012);
    wr(2'd2, 5'd31, 32'h1230_0001);
    wr(2'd2, 5'd2,  32'hB000_0000);
    wr(2'd1, 5'd0,  32'h0);
    wr(2'd0, 5'd0,  32'h1);

    // table walk: R4 R5 R6 R7 R11
    for (int k = 0; k < NV; k++) begin
      logic [31:0] va;
      logic [63:0] ve;
      logic        vh;
      {va, ve, vh} = VEC[k];
      xlate(vh ? "R6" : "R4_R7", va, ve, vh);
    end

    // R5 R8: 8 MB regions, index at [27:23]; offset bits [22:20] are dropped
    wr(2'd1, 5'd0, 32'h3);
    xlate("R8", 32'h6080_0123, 64'h0000_0012_A000_0123, 1'b1);
    // R5: 2 MB regions, index at [25:21]
    wr(2'd1, 5'd0, 32'h1);
    xlate("R5", 32'h6020_0000, 64'h0000_0012_A020_0000, 1'b1);

    // R9: size write and request in the same cycle use the old size
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'd1; cfg_idx = 5'd0; cfg_wdata = 32'h0;
    req_valid = 1'b1; req_addr = 32'h6020_0000;
    @(negedge clk);
    cfg_we = 1'b0; req_valid = 1'b0;
    check("R9", rsp_addr, rsp_hit, rsp_miss, rsp_valid, 64'h0000_0012_A020_0000, 1'b1, 1'b0, 1'b1);
    xlate("R9", 32'h6020_0000, 64'h0, 1'b0);

    // R7: clearing a region's enable bit turns its hits into misses
    wr(2'd2, 5'd0, 32'h9000_0000);
    xlate("R7", 32'h6001_5678, 64'h0, 1'b0);
    // R11: high offset change visible on hit
    wr(2'd3, 5'd1, 32'hDEAD_BEEF);
    xlate("R11", 32'h6012_3456, 64'hDEAD_BEEF_A032_3456, 1'b1);

    // R3: global disable restores pass-through even for a disabled region
    wr(2'd0, 5'd0, 32'h0);
    xlate("R3", 32'h6001_5678, 64'h0000_0000_6001_5678, 1'b1);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule